// File: doc/BRIEF.md
# Media Energy Auto-Sense Controller

This block sits beside a dual-media network controller. The controller's traffic runs over either a copper PHY or a SerDes/SGMII link. The block watches the port that is not carrying traffic for signal energy, so that software can decide whether to switch media. Three energy sources feed it:

- an external signal-detect pin;
- the SerDes electrical-idle indication;
- a PHY energy indication.

All three sources pass through a two-stage synchronizer. A detection is the rising edge of the selected source.

Software controls the block through a small register port with four addresses:

| Address | Register |
|---------|----------|
| 0 | Control |
| 1 | Cause |
| 2 | Mask |
| 3 | Link mode |

On a detection the block latches a sticky cause bit. Its interrupt line is the AND of that cause bit and the mask bit. The clean-up action depends on the detect mode. In SerDes detect mode the block disarms itself. In PHY detect mode it drives a PHY power-down output. A clean-up-hold bit turns off both clean-up actions and leaves them to software. The block also stores the 2-bit link-mode field that software uses for the media selection.

Top module: `media_sense_ctrl`

## Requirements
- R1: After reset the cause bit, mask bit, enable bit, config bit, hold bit, power-down output and link mode (00) are all zero. The source-select bit takes the value of the `nv_src_dflt` input.
- R2: The control register is at address 0 with these bits:
  - bit0: source select. 1 selects the external signal-detect pin and 0 selects the inverted electrical-idle input. This applies in SerDes detect mode.
  - bit1: sense enable.
  - bit2: config.
  - bit3: clean-up hold.
  - bit4: power-down release. It is write-only and reads as 0.
- R3: Energy inputs pass through two synchronizer flops. A 0-to-1 transition of the selected source while sense enable is 1 sets the cause bit (address 1, bit0). The cause bit is visible 3 clock edges after the input changes. A level that stays high does not set the cause bit again.
- R4: While sense enable is 0, the energy inputs have no effect on the cause bit.
- R5: Writing 1 to cause bit0 clears it. If a detection falls in the same cycle as that write, the detection wins and the cause bit stays 1.
- R6: `irq` equals cause bit0 AND mask bit0 (address 2).
- R7: In SerDes detect mode with the hold bit at 0, a detection clears sense enable. With the hold bit at 1, sense enable stays 1.
- R8: A control write with config=1 selects PHY detect mode. That mode stays selected until a control write has both config=0 and enable=0. While PHY detect mode is selected, the monitored source is the PHY energy input.
- R9: In PHY detect mode with the hold bit at 0, a detection sets `phy_pwr_down`. The output stays set until a control write with bit4=1 or a reset. With the hold bit at 1, the output does not change.
- R10: The link-mode field (address 3, bits 1:0) uses 00 for internal PHY, 10 for SerDes and 11 for SGMII. A write of 01 is ignored and the old value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_src_dflt | input | 1 | Reset value for source select, from non-volatile configuration |
| ext_sig_det | input | 1 | External signal-detect pin, asynchronous |
| serdes_idle | input | 1 | SerDes electrical idle, 1 = no energy |
| phy_energy | input | 1 | PHY energy indication, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt line |
| phy_pwr_down | output | 1 | PHY power-down request |
| link_mode | output | 2 | Link-mode field |

## Verification
Two events can fall in the same clock cycle: a new detection setting the cause bit, and a software write-1-to-clear of that same bit. To provoke the collision, the bench first leaves the cause bit set. It then raises an energy input and asserts the clear write exactly two edges later, so that the write lands in the same cycle as the synchronized edge. The cause bit must still read 1 afterwards, because losing an event would be a fault. The same set-wins rule for the power-down output is covered by an assertion placed beside its register.

// File: rtl/msc_pkg.sv
// Package: shared register addresses, field positions and link-mode codes
// for the media energy auto-sense controller.
package msc_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAUSE = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd3;

    localparam int B_SRC  = 0;
    localparam int B_EN   = 1;
    localparam int B_CFG  = 2;
    localparam int B_HOLD = 3;
    localparam int B_REL  = 4;

    typedef enum logic [1:0] {
        LM_PHY   = 2'b00,
        LM_RSVD  = 2'b01,
        LM_SERDES= 2'b10,
        LM_SGMII = 2'b11
    } link_mode_e;
endpackage

// File: rtl/msc_sync.sv
// Module: msc_sync
// Brings WIDTH asynchronous level signals into the clock domain through a
// chain of STAGES flops per bit. Assumes each input is a slow level, so that
// bits may be sampled independently.
module msc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/msc_detect.sv
// Module: msc_detect
// Picks the monitored energy source from the detect mode and the source
// select, and emits a one-cycle pulse on its rising edge while armed.
// Assumes the inputs are already synchronized. The edge history is tracked
// even while disarmed, so arming with a level already high does not fire.
module msc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic phy_mode,
    input  logic src_ext,
    input  logic ext_s,
    input  logic idle_s,
    input  logic phy_s,
    output logic det
);
    logic level, level_q;

    // Select which synchronized source represents energy on the idle media.
    always_comb begin
        if (phy_mode)     level = phy_s;
        else if (src_ext) level = ext_s;
        else              level = ~idle_s;
    end

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign det = armed & level & ~level_q;
endmodule

// File: rtl/msc_regs.sv
// Module: msc_regs
// Register file holding control, cause, mask and link mode, together with
// the detection side effects: cause set, auto-disarm and PHY power-down.
// Assumes a single-cycle write strobe. Software writes to enable take
// precedence over auto-disarm. Detection wins over software clears of the
// cause bit and of the power-down output.
module msc_regs
    import msc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_src_dflt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              det,
    output logic              src_ext,
    output logic              sense_en,
    output logic              phy_mode,
    output logic              cause,
    output logic              mask,
    output logic              pwr_down,
    output logic [1:0]        mode
);
    logic cfg, hold;
    logic wr_ctrl, wr_cause, wr_mask, wr_mode;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_cause = wr_en && (wr_addr == A_CAUSE);
    assign wr_mask  = wr_en && (wr_addr == A_MASK);
    assign wr_mode  = wr_en && (wr_addr == A_MODE);

    // Control bits: source select, config and hold follow software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ext <= nv_src_dflt;
            cfg     <= 1'b0;
            hold    <= 1'b0;
        end else if (wr_ctrl) begin
            src_ext <= wr_data[B_SRC];
            cfg     <= wr_data[B_CFG];
            hold    <= wr_data[B_HOLD];
        end
    end

    // Sense enable: a software write wins, otherwise a SerDes-mode detection disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sense_en <= 1'b0;
        else if (wr_ctrl)                    sense_en <= wr_data[B_EN];
        else if (det && !phy_mode && !hold)  sense_en <= 1'b0;
    end

    // Detect-mode flag: set by config=1 and kept until config and enable are both written 0.
    always_ff @(posedge clk) begin
        if (!rst_n) phy_mode <= 1'b0;
        else if (wr_ctrl) begin
            if (wr_data[B_CFG])                          phy_mode <= 1'b1;
            else if (!wr_data[B_EN])                     phy_mode <= 1'b0;
        end
    end

    // Sticky cause bit: detection sets it, write-one clears it, and the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cause <= 1'b0;
        else if (det)                      cause <= 1'b1;
        else if (wr_cause && wr_data[0])   cause <= 1'b0;
    end

    // Interrupt mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 1'b0;
        else if (wr_mask) mask <= wr_data[0];
    end

    // PHY power-down: set by a PHY-mode detection, released by the write-only release bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pwr_down <= 1'b0;
        else if (det && phy_mode && !hold)      pwr_down <= 1'b1;
        else if (wr_ctrl && wr_data[B_REL])     pwr_down <= 1'b0;
    end

    // Link-mode field; the reserved code is refused.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        mode <= LM_PHY;
        else if (wr_mode && (wr_data[1:0] != LM_RSVD))     mode <= wr_data[1:0];
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_SRC]  = src_ext;
                rd_data[B_EN]   = sense_en;
                rd_data[B_CFG]  = cfg;
                rd_data[B_HOLD] = hold;
            end
            A_CAUSE: rd_data[0]   = cause;
            A_MASK:  rd_data[0]   = mask;
            default: rd_data[1:0] = mode;
        endcase
    end

    assert_det_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> sense_en);
    assert_cause_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause) |-> $past(det));
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> cause);
    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (det && !phy_mode && !hold && !wr_ctrl) |=> !sense_en);
    assert_pd_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(det && phy_mode && !hold));
    assert_pd_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (det && phy_mode && !hold) |=> pwr_down);
    assert_no_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode != LM_RSVD);
endmodule

// File: rtl/media_sense_ctrl.sv
// Module: media_sense_ctrl
// Top level of the media energy auto-sense controller. It synchronizes the
// three energy sources, detects a rising edge on the monitored one and
// applies the register-controlled side effects. Assumes one clock domain
// for the register port.
module media_sense_ctrl
    import msc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_src_dflt,
    input  logic              ext_sig_det,
    input  logic              serdes_idle,
    input  logic              phy_energy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              phy_pwr_down,
    output logic [1:0]        link_mode
);
    localparam int N_SRC = 3;

    logic [N_SRC-1:0] raw_s, sync_s;
    logic det, src_ext, sense_en, phy_mode, cause, mask;

    assign raw_s = {phy_energy, serdes_idle, ext_sig_det};

    msc_sync #(.WIDTH(N_SRC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw_s), .sync_out(sync_s)
    );

    msc_detect u_det (
        .clk(clk), .rst_n(rst_n), .armed(sense_en), .phy_mode(phy_mode),
        .src_ext(src_ext), .ext_s(sync_s[0]), .idle_s(sync_s[1]),
        .phy_s(sync_s[2]), .det(det)
    );

    msc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .nv_src_dflt(nv_src_dflt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .det(det),
        .src_ext(src_ext), .sense_en(sense_en), .phy_mode(phy_mode),
        .cause(cause), .mask(mask), .pwr_down(phy_pwr_down), .mode(link_mode)
    );

    assign irq = cause & mask;

    assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_addr != A_MASK || rd_data[0]));
endmodule

// File: tb/sim_media_sense_ctrl.sv
module sim_media_sense_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, nv_src_dflt = 1;
    logic ext_sig_det = 0, serdes_idle = 1, phy_energy = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic irq, phy_pwr_down;
    logic [1:0] link_mode;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    media_sense_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .nv_src_dflt(nv_src_dflt),
        .ext_sig_det(ext_sig_det), .serdes_idle(serdes_idle), .phy_energy(phy_energy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .phy_pwr_down(phy_pwr_down), .link_mode(link_mode)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); check("R1 ctrl", d, 8'h01);
        rd(1, d); check("R1 cause", d, 8'h00);
        check("R1 pd", {7'd0, phy_pwr_down}, 0);
        check("R1 irq", {7'd0, irq}, 0);
        check("R1 mode", {6'd0, link_mode}, 0);
    endtask

    task automatic t_serdes_ext();
        logic [7:0] d;
        wr(2, 8'h01);
        wr(0, 8'h03);
        ext_sig_det = 1;
        wait_cyc(2);
        rd(1, d); check("R3 not yet", d, 0);
        wait_cyc(1);
        rd(1, d); check("R3 cause", d, 1);
        check("R6 irq", {7'd0, irq}, 1);
        rd(0, d); check("R7 disarm", d, 8'h01);
    endtask

    task automatic t_clear_level();
        logic [7:0] d;
        wr(1, 8'h01);
        rd(1, d); check("R5 w1c", d, 0);
        check("R6 irq low", {7'd0, irq}, 0);
        wr(0, 8'h03);
        wait_cyc(5);
        rd(1, d); check("R3 level no retrigger", d, 0);
        wr(0, 8'h01);
        ext_sig_det = 0;
        wait_cyc(3);
    endtask

    task automatic t_idle_src_hold();
        logic [7:0] d;
        wr(2, 8'h00);
        wr(0, 8'h0A);
        serdes_idle = 0;
        wait_cyc(3);
        rd(1, d); check("R2 idle src cause", d, 1);
        check("R6 masked", {7'd0, irq}, 0);
        rd(0, d); check("R7 hold keeps en", d, 8'h0A);
        wr(0, 8'h00);
        serdes_idle = 1;
        wr(1, 8'h01);
        wait_cyc(3);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        wr(0, 8'h01);
        ext_sig_det = 1;
        wait_cyc(4);
        rd(1, d); check("R4 ignored", d, 0);
        ext_sig_det = 0;
        wait_cyc(3);
    endtask

    task automatic t_phy_mode();
        logic [7:0] d;
        wr(0, 8'h04);
        wr(0, 8'h02);
        ext_sig_det = 1;
        wait_cyc(4);
        rd(1, d); check("R8 ext unused in phy mode", d, 0);
        phy_energy = 1;
        wait_cyc(3);
        rd(1, d); check("R8 phy cause", d, 1);
        check("R9 pd set", {7'd0, phy_pwr_down}, 1);
        wr(1, 8'h01);
        phy_energy = 0; ext_sig_det = 0;
        wait_cyc(3);
        check("R9 pd held", {7'd0, phy_pwr_down}, 1);
        wr(0, 8'h10);
        check("R9 pd released", {7'd0, phy_pwr_down}, 0);
        wr(0, 8'h0C);
        wr(0, 8'h0A);
        phy_energy = 1;
        wait_cyc(3);
        rd(1, d); check("R9 hold cause", d, 1);
        check("R9 hold no pd", {7'd0, phy_pwr_down}, 0);
        wr(0, 8'h00);
        phy_energy = 0;
        wr(1, 8'h01);
        wait_cyc(3);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        wr(0, 8'h0B);
        ext_sig_det = 1;
        wait_cyc(3);
        ext_sig_det = 0;
        wait_cyc(3);
        rd(1, d); check("R5 precondition", d, 1);
        ext_sig_det = 1;
        wait_cyc(2);
        wr(1, 8'h01);
        rd(1, d); check("R5 set wins", d, 1);
        wr(1, 8'h01);
        rd(1, d); check("R5 clear after", d, 0);
        wr(0, 8'h01);
        ext_sig_det = 0;
    endtask

    task automatic t_mode();
        wr(3, 8'h02); check("R10 serdes", {6'd0, link_mode}, 2);
        wr(3, 8'h01); check("R10 rsvd ignored", {6'd0, link_mode}, 2);
        wr(3, 8'h03); check("R10 sgmii", {6'd0, link_mode}, 3);
        wr(3, 8'h00); check("R10 phy", {6'd0, link_mode}, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_serdes_ext();
        t_clear_level();
        t_idle_src_hold();
        t_disabled();
        t_phy_mode();
        t_collide();
        t_mode();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule